// File: doc/BRIEF.md
# Printer Port Register Interface

This block is a byte-wide printer port controller that a host drives through a small register bus. The bus has an address, a write strobe, a read strobe and separate 8-bit write and read data. Inside sit an output data latch, an input data latch, a status register and a control register. The strobe, busy and acknowledge handshake of a printer is modelled in the status and control bits, so the block needs no printer attached.

Software prints a byte in three steps. It writes the byte to the data offset. It then raises the strobe bit in the control register while init and select are high. The block places that byte on a valid/ready output stream. Reads of the status register then step the acknowledge and busy bits through the sequence that a real printer would produce. A level interrupt line signals that software pulsed the strobe low with interrupts enabled. A status read clears it.

The input latch is loaded from a separate input byte under a load strobe. Software reads it through the data offset when the direction bit selects input. If a write and a read strobe arrive in the same cycle, the write is performed and the read is ignored.

Top module: `prt_port_regs`

## Requirements
- R1: After reset, a status read returns 0xD9, a control read returns 0xCC, a data read returns 0xFF, irq is 0 and out_valid is 0. Both data latches hold 0xFF and no interrupt is pending.
- R2: The register offset is reg_addr modulo 8: offset 0 is data, 1 is status and 2 is control. A read of offsets 3 to 7 returns 0xFF and a write to them changes nothing. Read data appears on reg_rdata the cycle after the read strobe and holds until the next read.
- R3: Every control write stores the written value with bits 7 and 6 forced to 1. A control read returns the stored value.
- R4: A data read returns the input latch when control bit 5 (direction) is 1, and the output latch when it is 0. A data write loads the output latch.
- R5: A control write with bit 2 (init) at 0 loads status with 0xD8.
- R6: A control write with bit 2 (init) at 1, bit 3 (select) at 1 and bit 0 (strobe) at 1 clears status bit 7. If the stored strobe bit was 0 before the write, the output latch byte is queued on the stream. If the stored strobe bit was already 1, nothing is queued.
- R7: A control write with init 1, select 1 and strobe 0 sets the pending interrupt if the stored control bit 4 (interrupt enable) was 1 before the write. irq shows the pending flag from the cycle after the write. With select 0 the interrupt is not set.
- R8: A status read returns the current status and clears the pending interrupt, so irq is 0 from the next cycle.
- R9: After a status read, if status bit 7 is 0 and the stored strobe bit is 0, the status changes as follows. If bit 6 (acknowledge) is set, it is cleared. Otherwise bits 7 and 6 are both set.
- R10: Queued bytes leave on out_data/out_valid in the order they were queued, with one byte moving on each cycle where out_valid and out_ready are both 1. While out_ready is 0 the byte on the stream holds. The queue holds DEPTH bytes (default 2). A strobe edge that finds it full queues nothing.
- R11: din_load high at a clock edge copies din into the input latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register address, decoded modulo 8 |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| din | input | 8 | Byte for the input latch |
| din_load | input | 1 | Load din into the input latch |
| irq | output | 1 | Level interrupt |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_ready | input | 1 | Stream consumer ready |

## Verification
Every register access takes effect at the rising edge that samples its strobe. The read data, the status side effects and the interrupt level are therefore all due one edge after the access, and a byte queued by a strobe edge is on the stream after that same edge. The bench drives each strobe on a falling edge and holds it for one rising edge. It samples reg_rdata, irq and the stream at the following falling edge, so every check falls in the first cycle in which the result is due. Stream pops open out_ready for exactly one rising edge, and the next byte is checked at the falling edge after it.

// File: rtl/prt_pkg.sv
package prt_pkg;

    // Control register bit positions.
    localparam int CTL_STB = 0;
    localparam int CTL_ALF = 1;
    localparam int CTL_INI = 2;
    localparam int CTL_SEL = 3;
    localparam int CTL_IEN = 4;
    localparam int CTL_DIR = 5;

    // Status register bit positions.
    localparam int STS_NBSY = 7;
    localparam int STS_ACK  = 6;

    // Register offsets within the 8-byte window.
    localparam logic [2:0] OFF_DATA = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd1;
    localparam logic [2:0] OFF_CTRL = 3'd2;

    // Reset and load values.
    localparam logic [7:0] DATA_RST   = 8'hFF;
    localparam logic [7:0] STAT_RST   = 8'hD9;
    localparam logic [7:0] CTRL_RST   = 8'hCC;
    localparam logic [7:0] STAT_INIT  = 8'hD8;
    localparam logic [7:0] CTRL_FORCE = 8'hC0;
    localparam logic [7:0] IDLE_READ  = 8'hFF;

    typedef struct packed {
        logic [7:0] dout;
        logic [7:0] din;
        logic [7:0] status;
        logic [7:0] ctrl;
        logic [7:0] rdata;
        logic       pend;
    } prt_regs_t;

endpackage

// File: rtl/prt_regfile.sv
module prt_regfile
    import prt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [7:0]        wdata_i,
    input  logic [7:0]        din_i,
    input  logic              din_load_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o,
    output logic              emit_o,
    output logic [7:0]        emit_byte_o
);

    prt_regs_t  regs_d, regs_q;
    logic [2:0] off;
    logic [7:0] ctl_new;

    assign off = addr_i[2:0];

    always_comb begin
        regs_d  = regs_q;
        emit_o  = 1'b0;
        ctl_new = wdata_i | CTRL_FORCE;

        if (din_load_i) begin
            regs_d.din = din_i;
        end

        if (wr_i) begin
            case (off)
                OFF_DATA: regs_d.dout = wdata_i;
                OFF_CTRL: begin
                    if (!ctl_new[CTL_INI]) begin
                        regs_d.status = STAT_INIT;
                    end else if (ctl_new[CTL_SEL]) begin
                        if (ctl_new[CTL_STB]) begin
                            regs_d.status[STS_NBSY] = 1'b0;
                            if (!regs_q.ctrl[CTL_STB]) begin
                                emit_o = 1'b1;
                            end
                        end else if (regs_q.ctrl[CTL_IEN]) begin
                            regs_d.pend = 1'b1;
                        end
                    end
                    regs_d.ctrl = ctl_new;
                end
                default: ;
            endcase
        end else if (rd_i) begin
            case (off)
                OFF_DATA: regs_d.rdata = regs_q.ctrl[CTL_DIR] ? regs_q.din : regs_q.dout;
                OFF_STAT: begin
                    regs_d.rdata = regs_q.status;
                    regs_d.pend  = 1'b0;
                    if (!regs_q.status[STS_NBSY] && !regs_q.ctrl[CTL_STB]) begin
                        if (regs_q.status[STS_ACK]) begin
                            regs_d.status[STS_ACK] = 1'b0;
                        end else begin
                            regs_d.status[STS_ACK]  = 1'b1;
                            regs_d.status[STS_NBSY] = 1'b1;
                        end
                    end
                end
                OFF_CTRL: regs_d.rdata = regs_q.ctrl;
                default:  regs_d.rdata = IDLE_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.dout   <= DATA_RST;
            regs_q.din    <= DATA_RST;
            regs_q.status <= STAT_RST;
            regs_q.ctrl   <= CTRL_RST;
            regs_q.rdata  <= IDLE_READ;
            regs_q.pend   <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata_o     = regs_q.rdata;
    assign irq_o       = regs_q.pend;
    assign emit_byte_o = regs_q.dout;

endmodule

// File: rtl/prt_fifo.sv
module prt_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    output logic         full_o,
    output logic         valid_o,
    output logic [W-1:0] data_o,
    input  logic         ready_i
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        head;
        logic [PTR_W-1:0]        tail;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic  do_push, do_pop;

    always_comb begin
        fifo_d  = fifo_q;
        do_pop  = (fifo_q.cnt != '0) && ready_i;
        do_push = push_i && (fifo_q.cnt != CNT_FULL);

        if (do_push) begin
            fifo_d.mem[fifo_q.tail] = push_data_i;
            fifo_d.tail = (fifo_q.tail == PTR_LAST) ? '0 : fifo_q.tail + 1'b1;
        end
        if (do_pop) begin
            fifo_d.head = (fifo_q.head == PTR_LAST) ? '0 : fifo_q.head + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   fifo_d.cnt = fifo_q.cnt + 1'b1;
            2'b01:   fifo_d.cnt = fifo_q.cnt - 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_q.mem  <= '0;
            fifo_q.head <= '0;
            fifo_q.tail <= '0;
            fifo_q.cnt  <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    assign full_o  = (fifo_q.cnt == CNT_FULL);
    assign valid_o = (fifo_q.cnt != '0);
    assign data_o  = fifo_q.mem[fifo_q.head];

endmodule

// File: rtl/prt_port_regs.sv
module prt_port_regs #(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [7:0]        din,
    input  logic              din_load,
    output logic              irq,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready
);

    logic       emit;
    logic [7:0] emit_byte;
    logic       q_full;

    prt_regfile #(.ADDR_W(ADDR_W)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (reg_addr),
        .wr_i        (reg_wr),
        .rd_i        (reg_rd),
        .wdata_i     (reg_wdata),
        .din_i       (din),
        .din_load_i  (din_load),
        .rdata_o     (reg_rdata),
        .irq_o       (irq),
        .emit_o      (emit),
        .emit_byte_o (emit_byte)
    );

    prt_fifo #(.DEPTH(DEPTH), .W(8)) i_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (emit),
        .push_data_i (emit_byte),
        .full_o      (q_full),
        .valid_o     (out_valid),
        .data_o      (out_data),
        .ready_i     (out_ready)
    );

endmodule

// File: rtl/prt_port_chk.sv
module prt_port_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [7:0]        reg_rdata,
    input logic              irq,
    input logic              out_valid,
    input logic [7:0]        out_data,
    input logic              out_ready
);

    logic rd_only;
    assign rd_only = reg_rd && !reg_wr;

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && reg_addr[2:0] == 3'd1) |=> !irq);

    // R3
    ctl_high_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && reg_addr[2:0] == 3'd2) |=> (reg_rdata[7:6] == 2'b11));

    // R2
    unused_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && reg_addr[2:0] > 3'd2) |=> (reg_rdata == 8'hFF));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_only |=> $stable(reg_rdata));

    // R10
    stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(reg_wr && reg_addr[2:0] == 3'd2)) |=> !irq);

endmodule

bind prt_port_regs prt_port_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
);

// File: tb/test_prt_port_regs.sv
`timescale 1ns/1ps
module test_prt_port_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] din = '0;
    logic       din_load = 1'b0;
    logic       irq;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    prt_port_regs #(.ADDR_W(4), .DEPTH(2)) i_prt_port_regs (
        .clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
        .din, .din_load, .irq, .out_valid, .out_data, .out_ready
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pop_one();
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic print_byte(input logic [7:0] b);
        wr(4'd0, b);
        wr(4'd2, 8'hCD);
        wr(4'd2, 8'hCC);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 out_valid", {7'd0, out_valid}, 8'h00);
        rd(4'd1, v); check("R1 status", v, 8'hD9);
        rd(4'd2, v); check("R1 control", v, 8'hCC);
        rd(4'd0, v); check("R1 data", v, 8'hFF);
    endtask

    task automatic t_decode();
        logic [7:0] v;
        wr(4'd0, 8'h5A);
        rd(4'd0, v); check("R4 data write/read", v, 8'h5A);
        wr(4'd5, 8'h00);
        wr(4'd3, 8'h00);
        rd(4'd2, v); check("R2 ignored write ctrl", v, 8'hCC);
        rd(4'd0, v); check("R2 ignored write data", v, 8'h5A);
        rd(4'd1, v); check("R2 ignored write status", v, 8'hD9);
        rd(4'd3, v); check("R2 offset 3 read", v, 8'hFF);
        rd(4'd7, v); check("R2 offset 7 read", v, 8'hFF);
        wr(4'd8, 8'h3C);
        rd(4'd0, v); check("R2 wrapped data offset", v, 8'h3C);
        rd(4'd10, v); check("R2 wrapped control offset", v, 8'hCC);
    endtask

    task automatic t_ctrl_fixed();
        logic [7:0] v;
        wr(4'd2, 8'h05);
        rd(4'd2, v); check("R3 forced high bits", v, 8'hC5);
        rd(4'd1, v); check("R3 select low leaves status", v, 8'hD9);
        wr(4'd2, 8'hCC);
    endtask

    task automatic t_dir();
        logic [7:0] v;
        rd(4'd0, v); check("R11 latch before load", v, 8'h3C);
        @(negedge clk);
        din = 8'hA7; din_load = 1'b1;
        @(negedge clk);
        din_load = 1'b0; din = 8'h00;
        wr(4'd2, 8'hEC);
        rd(4'd0, v); check("R11 R4 input latch read", v, 8'hA7);
        wr(4'd2, 8'hCC);
        rd(4'd0, v); check("R4 output latch read", v, 8'h3C);
    endtask

    task automatic t_init();
        logic [7:0] v;
        wr(4'd2, 8'hC8);
        rd(4'd1, v); check("R5 init low status", v, 8'hD8);
        rd(4'd1, v); check("R5 status stable with busy high", v, 8'hD8);
        wr(4'd2, 8'hCC);
    endtask

    task automatic t_strobe_ack();
        logic [7:0] v;
        out_ready = 1'b0;
        wr(4'd0, 8'h11);
        wr(4'd2, 8'hCD);
        check("R6 byte queued valid", {7'd0, out_valid}, 8'h01);
        check("R6 byte queued data", out_data, 8'h11);
        rd(4'd1, v); check("R6 busy bit cleared", v, 8'h58);
        rd(4'd1, v); check("R9 no step with strobe high", v, 8'h58);
        wr(4'd2, 8'hCD);
        wr(4'd2, 8'hCC);
        rd(4'd1, v); check("R9 read before ack clear", v, 8'h58);
        rd(4'd1, v); check("R9 ack cleared", v, 8'h18);
        rd(4'd1, v); check("R9 ack and busy set", v, 8'hD8);
        rd(4'd1, v); check("R9 sequence idle", v, 8'hD8);
        pop_one();
        check("R6 repeated strobe queued nothing", {7'd0, out_valid}, 8'h00);
    endtask

    task automatic t_stream();
        out_ready = 1'b0;
        print_byte(8'h21);
        print_byte(8'h22);
        print_byte(8'h23);
        repeat (3) @(negedge clk);
        check("R10 held first byte", out_data, 8'h21);
        check("R10 held valid", {7'd0, out_valid}, 8'h01);
        pop_one();
        check("R10 second byte in order", out_data, 8'h22);
        check("R10 second valid", {7'd0, out_valid}, 8'h01);
        pop_one();
        check("R10 full queue refused third", {7'd0, out_valid}, 8'h00);
        print_byte(8'h24);
        check("R10 after drain", out_data, 8'h24);
        pop_one();
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(4'd2, 8'hDC);
        check("R7 enable set by same write gives no irq", {7'd0, irq}, 8'h00);
        wr(4'd2, 8'hDC);
        check("R7 irq raised", {7'd0, irq}, 8'h01);
        rd(4'd0, v);
        check("R8 data read keeps irq", {7'd0, irq}, 8'h01);
        rd(4'd1, v);
        check("R8 status read clears irq", {7'd0, irq}, 8'h00);
        wr(4'd2, 8'hD4);
        check("R7 select low gives no irq", {7'd0, irq}, 8'h00);
        wr(4'd2, 8'hCC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_ctrl_fixed();
        t_dir();
        t_init();
        t_strobe_ack();
        t_stream();
        t_irq();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule